// File: doc/BRIEF.md
# Bridge Error Status Capture Registers

This block holds the error-event record of a bus bridge in two small status registers. The first is the standard status register. It keeps a signaled-target-abort flag and a signaled-system-error flag. The second is a bridge-specific error register. It keeps a flag for "the local-bus master saw a bus error" and a flag for "the system error was raised because of a local-bus error". Four single-cycle pulse inputs report the events. Every flag is sticky and cannot be masked: an event always sets its flag, and no enable or command setting can block it.

Software reads the flags and clears them through a simple register port. The port has a byte address, write data, a write strobe and a registered read-data output. Writing 1 to a flag clears it, and writing 0 leaves it as it is. A single system-error event that carries the local-bus cause sets flags in both registers in the same cycle. When an event and a clearing write hit one flag together, the event wins, so no error is ever lost.

Top module: `brerr_status_regs`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, both registers clear to 0, and `cfg_rdata` clears to 0.
- R2: A pulse on `ev_tabort` sets bit 11 of the standard status register (address 0x06) at the next clock edge.
- R3: A pulse on `ev_serr` sets bit 14 of the standard status register at the next clock edge.
- R4: When `ev_serr` and `ev_serr_lbus` are high together, bit 1 of the bridge error register (address 0x48) is set at the same edge as R3. `ev_serr_lbus` without `ev_serr` has no effect on either register.
- R5: A pulse on `ev_lbus_merr` sets bit 0 of the bridge error register at the next clock edge.
- R6: A set flag stays set until it is cleared by a write. No other input clears it or keeps it from being set.
- R7: A write (`cfg_wr`=1) to address 0x06 or 0x48 clears each flag whose `cfg_wdata` bit is 1. It leaves each flag whose bit is 0 unchanged. A write to any other address changes nothing.
- R8: If an event and a clearing write hit the same flag in the same cycle, the flag is 1 after that edge.
- R9: `cfg_rdata` shows, one clock after `cfg_addr` is presented, the value the addressed register held at that edge. Unassigned bits, and every address other than 0x06 and 0x48, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_tabort | input | 1 | Target side issued a target abort (pulse) |
| ev_serr | input | 1 | Target side asserted system error (pulse) |
| ev_serr_lbus | input | 1 | Qualifier: this system error was caused by a local-bus error |
| ev_lbus_merr | input | 1 | Local-bus master received a bus error (pulse) |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 16 | Write data (1 bits clear flags) |
| cfg_wr | input | 1 | Write strobe |
| cfg_rdata | output | 16 | Registered read data |

## Verification
A flag's set path and its write-one-to-clear path can act in the same cycle. The bench provokes this by sweeping all sixteen combinations of the four event pulses against four write variants: no write, all-ones to each register, and all-ones to an unmapped address. It does this from both an all-set and an all-clear starting state. Each result is read back through the port and compared with a bench model in which the set term takes priority over the clear term.

// File: rtl/brerr_pkg.sv
package brerr_pkg;
   typedef struct packed {
      logic tabort;
      logic serr;
      logic serr_lbus;
      logic lbus_merr;
   } brerr_ev_t;

   function automatic logic [15:0] bit_at(input int unsigned pos);
      logic [15:0] m;
      m = '0;
      m[pos] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/w1c_cell.sv
module w1c_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end
endmodule

// File: rtl/w1c_bank.sv
module w1c_bank #(
   parameter int unsigned        W    = 16,
   parameter logic [W-1:0]       MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_live
         w1c_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(set_i[i]),
            .clr_i(clr_i[i]),
            .q_o  (q_o[i])
         );
      end else begin : g_tie
         assign q_o[i] = 1'b0;
         logic unused_in;
         assign unused_in = set_i[i] ^ clr_i[i];
      end
   end
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux #(
   parameter int unsigned    AW     = 8,
   parameter int unsigned    W      = 16,
   parameter logic [AW-1:0]  ADDR_A = '0,
   parameter logic [AW-1:0]  ADDR_B = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  val_a,
   input  logic [W-1:0]  val_b,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] sel;

   always_comb begin
      if (addr == ADDR_A)      sel = val_a;
      else if (addr == ADDR_B) sel = val_b;
      else                     sel = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= sel;
   end
endmodule

// File: rtl/brerr_status_regs.sv
module brerr_status_regs
   import brerr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 16,
   parameter logic [7:0]  STD_ADDR = 8'h06,
   parameter logic [7:0]  ERR_ADDR = 8'h48,
   parameter int unsigned TA_BIT   = 11,
   parameter int unsigned SE_BIT   = 14,
   parameter int unsigned MED_BIT  = 0,
   parameter int unsigned SLE_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_tabort,
   input  logic              ev_serr,
   input  logic              ev_serr_lbus,
   input  logic              ev_lbus_merr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              cfg_wr,
   output logic [DATA_W-1:0] cfg_rdata
);
   localparam logic [DATA_W-1:0] STD_MASK = DATA_W'(bit_at(TA_BIT) | bit_at(SE_BIT));
   localparam logic [DATA_W-1:0] ERR_MASK = DATA_W'(bit_at(MED_BIT) | bit_at(SLE_BIT));
   localparam logic [ADDR_W-1:0] STD_A    = ADDR_W'(STD_ADDR);
   localparam logic [ADDR_W-1:0] ERR_A    = ADDR_W'(ERR_ADDR);

   if (DATA_W != 16) begin : g_bad_w
      $error("DATA_W must be 16");
   end
   if (ADDR_W < 7 || ADDR_W > 8) begin : g_bad_aw
      $error("ADDR_W must hold both register addresses");
   end
   if (STD_ADDR == ERR_ADDR) begin : g_bad_addr
      $error("register addresses must differ");
   end
   if (TA_BIT == SE_BIT || MED_BIT == SLE_BIT ||
       TA_BIT >= DATA_W || SE_BIT >= DATA_W ||
       MED_BIT >= DATA_W || SLE_BIT >= DATA_W) begin : g_bad_bits
      $error("flag positions must be distinct and inside DATA_W");
   end

   brerr_ev_t         ev;
   logic [DATA_W-1:0] std_set, err_set, std_clr, err_clr;
   logic [DATA_W-1:0] std_q, err_q;

   assign ev = '{tabort: ev_tabort, serr: ev_serr,
                 serr_lbus: ev_serr_lbus, lbus_merr: ev_lbus_merr};

   always_comb begin
      std_set          = '0;
      err_set          = '0;
      std_set[TA_BIT]  = ev.tabort;
      std_set[SE_BIT]  = ev.serr;
      err_set[SLE_BIT] = ev.serr & ev.serr_lbus;
      err_set[MED_BIT] = ev.lbus_merr;
      std_clr = (cfg_wr && cfg_addr == STD_A) ? cfg_wdata : '0;
      err_clr = (cfg_wr && cfg_addr == ERR_A) ? cfg_wdata : '0;
   end

   w1c_bank #(.W(DATA_W), .MASK(STD_MASK)) u_std (
      .clk(clk), .rst_n(rst_n), .set_i(std_set), .clr_i(std_clr), .q_o(std_q)
   );

   w1c_bank #(.W(DATA_W), .MASK(ERR_MASK)) u_err (
      .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .q_o(err_q)
   );

   cfg_rd_mux #(.AW(ADDR_W), .W(DATA_W), .ADDR_A(STD_A), .ADDR_B(ERR_A)) u_rd (
      .clk(clk), .rst_n(rst_n), .addr(cfg_addr),
      .val_a(std_q), .val_b(err_q), .rdata(cfg_rdata)
   );
endmodule

// File: rtl/brerr_status_chk.sv
module brerr_status_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 16,
   parameter logic [7:0]  STD_ADDR = 8'h06,
   parameter logic [7:0]  ERR_ADDR = 8'h48,
   parameter int unsigned TA_BIT   = 11,
   parameter int unsigned SE_BIT   = 14,
   parameter int unsigned MED_BIT  = 0,
   parameter int unsigned SLE_BIT  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_tabort,
   input logic              ev_serr,
   input logic              ev_serr_lbus,
   input logic              ev_lbus_merr,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              cfg_wr,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic [DATA_W-1:0] std_q,
   input logic [DATA_W-1:0] err_q
);
   localparam logic [ADDR_W-1:0] STD_A = ADDR_W'(STD_ADDR);
   localparam logic [ADDR_W-1:0] ERR_A = ADDR_W'(ERR_ADDR);

   logic std_wr, err_wr;
   assign std_wr = cfg_wr && cfg_addr == STD_A;
   assign err_wr = cfg_wr && cfg_addr == ERR_A;

   // R2
   tabort_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tabort |=> std_q[TA_BIT]);

   // R4
   serr_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_serr && ev_serr_lbus) |=> (std_q[SE_BIT] && err_q[SLE_BIT]));

   // R5
   merr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_lbus_merr |=> err_q[MED_BIT]);

   // R6
   ta_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_tabort && !(std_wr && cfg_wdata[TA_BIT])) |=> $stable(std_q[TA_BIT]));

   // R7
   med_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_wr && cfg_wdata[MED_BIT] && !ev_lbus_merr) |=> !err_q[MED_BIT]);

   // R8
   se_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_serr && std_wr && cfg_wdata[SE_BIT]) |=> std_q[SE_BIT]);

   // R9
   std_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_addr) == STD_A) |-> cfg_rdata == $past(std_q));
endmodule

bind brerr_status_regs brerr_status_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STD_ADDR(STD_ADDR), .ERR_ADDR(ERR_ADDR),
   .TA_BIT(TA_BIT), .SE_BIT(SE_BIT), .MED_BIT(MED_BIT), .SLE_BIT(SLE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_tabort(ev_tabort), .ev_serr(ev_serr),
   .ev_serr_lbus(ev_serr_lbus), .ev_lbus_merr(ev_lbus_merr),
   .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr),
   .cfg_rdata(cfg_rdata), .std_q(std_q), .err_q(err_q)
);

// File: tb/sim_brerr_status_regs.sv
`timescale 1ns/1ps
module sim_brerr_status_regs;
   localparam logic [7:0]  A_STD = 8'h06;
   localparam logic [7:0]  A_ERR = 8'h48;
   localparam logic [15:0] M_STD = 16'h4800;
   localparam logic [15:0] M_ERR = 16'h0003;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_tabort = 0, ev_serr = 0, ev_serr_lbus = 0, ev_lbus_merr = 0;
   logic [7:0]  cfg_addr = 8'h00;
   logic [15:0] cfg_wdata = 16'h0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_rdata;

   int          n_run = 0, n_fail = 0;
   logic [15:0] m_std = 0, m_err = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   brerr_status_regs u0 (
      .clk(clk), .rst_n(rst_n), .ev_tabort(ev_tabort), .ev_serr(ev_serr),
      .ev_serr_lbus(ev_serr_lbus), .ev_lbus_merr(ev_lbus_merr),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr),
      .cfg_rdata(cfg_rdata)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // ev = {tabort, serr, serr_lbus, lbus_merr}
   task automatic step(input logic [3:0] ev, input logic wr, input logic [7:0] a,
                       input logic [15:0] wd);
      logic [15:0] s_std, s_err, c_std, c_err;
      @(negedge clk);
      {ev_tabort, ev_serr, ev_serr_lbus, ev_lbus_merr} = ev;
      cfg_wr = wr; cfg_addr = a; cfg_wdata = wd;
      @(posedge clk);
      s_std = ({15'b0, ev[3]} << 11) | ({15'b0, ev[2]} << 14);
      s_err = {15'b0, ev[0]} | ({15'b0, ev[2] & ev[1]} << 1);
      c_std = (wr && a == A_STD) ? wd : 16'h0;
      c_err = (wr && a == A_ERR) ? wd : 16'h0;
      m_std = (s_std | (m_std & ~c_std)) & M_STD;
      m_err = (s_err | (m_err & ~c_err)) & M_ERR;
      @(negedge clk);
      {ev_tabort, ev_serr, ev_serr_lbus, ev_lbus_merr} = 4'b0;
      cfg_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, input string req, input logic [15:0] exp);
      @(negedge clk);
      cfg_addr = a; cfg_wr = 0;
      @(posedge clk);
      #5 check(req, cfg_rdata, exp);
   endtask

   initial begin
      #(20.0 * 200000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #5 check("R1 rdata in reset", cfg_rdata, 16'h0);
      @(negedge clk) rst_n = 1'b1;
      rd(A_STD, "R1 std after reset", 16'h0);
      rd(A_ERR, "R1 err after reset", 16'h0);

      step(4'b1000, 0, 8'h00, 0);
      rd(A_STD, "R2 target abort sets bit 11", m_std);
      step(4'b0100, 0, 8'h00, 0);
      rd(A_STD, "R3 system error sets bit 14", 16'h4800);
      rd(A_ERR, "R4 serr alone leaves err", 16'h0000);
      step(4'b0010, 0, 8'h00, 0);
      rd(A_ERR, "R4 qualifier alone no effect", 16'h0000);
      step(4'b0110, 0, 8'h00, 0);
      rd(A_ERR, "R4 serr with lbus sets bit 1", 16'h0002);
      step(4'b0001, 0, 8'h00, 0);
      rd(A_ERR, "R5 master error sets bit 0", 16'h0003);
      step(4'b0000, 1, 8'h10, 16'hFFFF);
      rd(A_STD, "R6 flags held std", 16'h4800);
      rd(A_ERR, "R6 flags held err", 16'h0003);
      step(4'b0000, 1, A_STD, 16'h0000);
      rd(A_STD, "R7 write zero keeps", 16'h4800);
      step(4'b0000, 1, A_STD, 16'h0800);
      rd(A_STD, "R7 write one clears bit 11 only", 16'h4000);
      step(4'b0000, 1, A_ERR, 16'h0002);
      rd(A_ERR, "R7 write one clears bit 1 only", 16'h0001);
      step(4'b1000, 1, A_STD, 16'hFFFF);
      rd(A_STD, "R8 set beats clear", 16'h0800);
      rd(8'h07, "R9 unmapped address reads 0", 16'h0);
      rd(8'h49, "R9 neighbour address reads 0", 16'h0);

      for (int pre = 0; pre < 2; pre++) begin
         for (int ev = 0; ev < 16; ev++) begin
            for (int wm = 0; wm < 4; wm++) begin
               if (pre == 1) step(4'b1111, 0, 8'h00, 0);
               else begin
                  step(4'b0000, 1, A_STD, 16'hFFFF);
                  step(4'b0000, 1, A_ERR, 16'hFFFF);
               end
               case (wm)
                  0: step(4'(ev), 0, 8'h00, 16'h0);
                  1: step(4'(ev), 1, A_STD, 16'hFFFF);
                  2: step(4'(ev), 1, A_ERR, 16'hFFFF);
                  default: step(4'(ev), 1, 8'h20, 16'hFFFF);
               endcase
               rd(A_STD, "R8 sweep std", m_std);
               rd(A_ERR, "R8 sweep err", m_err);
            end
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule